// File: doc/BRIEF.md
# I2C Event Flag and Interrupt Controller

This block is the status and interrupt part of a byte-oriented I2C peripheral. An external protocol engine sends single-cycle pulses for nine bus events: start sent, 10-bit header sent, address matched, byte received, byte transmitted, stop detected, acknowledge failed, arbitration lost and bus error. The block holds each event as a sticky flag. The flags are split across two status registers that a CPU reads over a simple single-cycle register bus. The block also forms a summary event bit and one combined interrupt request.

Flags are not cleared by writing ones. Each flag clears only when the CPU performs the access pattern assigned to it. Most patterns are a read of status register A followed directly by a particular data or control access. A small state machine tracks the first half of these patterns. Its state `SEQ_IDLE` moves to `SEQ_ARMED` on a status A read (transition *arm*). In `SEQ_ARMED`, a further status A read keeps it there (transition *re-arm*). Any other access completes or cancels the pattern and returns it to `SEQ_IDLE` (transition *finish*). An idle cycle holds the state, and so does the freeze input. A freeze input holds every register and flag while the chip is in a low-power halt state.

Top module: `i2c_evt_irq_ctrl`

## Requirements
- R1: After reset, all eight flags, the summary bit, the control register and `irq_o` are 0, and the sequencer is in `SEQ_IDLE`.
- R2: Register addresses are 0 control, 1 status A, 2 status B and 3 data. Status A reads {summary, 3'b0, byte-done, address-match, 10-bit-header, start} with the summary bit at bit 7. Status B reads {4'b0, bus-error, arbitration-lost, ack-failed, stop}. Each event pulse sets its flag. A byte pulse of either direction sets byte-done. The summary bit is the OR of all eight flags.
- R3: A read of status B clears the stop, ack-failed, arbitration-lost and bus-error flags, and cancels a pending status A read.
- R4: A status A read followed directly by a data write clears the start and 10-bit-header flags. It also clears byte-done if the last byte event was a transmit.
- R5: A status A read followed directly by a data read clears byte-done if the last byte event was a receive. If receive and transmit pulse together, the byte counts as a receive. A data read returns `rx_data_i`.
- R6: A status A read followed directly by a control write clears the address-match flag.
- R7: Repeated status A reads keep the sequence pending. Any other access completes or cancels it. The second step of a pattern without a directly preceding status A read clears nothing. Cycles without an access leave a pending sequence in place.
- R8: When a set pulse and a completing clear for the same flag fall in the same cycle, the flag stays set.
- R9: `irq_o` is 1 exactly when the summary bit is 1, control bit 0 is 1 and `imask_i` is 0.
- R10: While `freeze_i` is 1, event pulses and bus writes are ignored, and reads change no state. Flags, the control register and the sequencer hold their values.
- R11: A control write stores the whole byte. The stored byte is read back at address 0 and driven on `ctrl_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Holds all state while high |
| imask_i | input | 1 | CPU global interrupt mask, 1 = masked |
| ev_start_i | input | 1 | Start condition sent pulse |
| ev_hdr10_i | input | 1 | 10-bit address header sent pulse |
| ev_match_i | input | 1 | Own address matched pulse |
| ev_byte_rx_i | input | 1 | Byte received pulse |
| ev_byte_tx_i | input | 1 | Byte transmitted pulse |
| ev_stop_i | input | 1 | Stop condition detected pulse |
| ev_ack_fail_i | input | 1 | Acknowledge failure pulse |
| ev_arb_lost_i | input | 1 | Arbitration lost pulse |
| ev_bus_err_i | input | 1 | Bus error pulse |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| rx_data_i | input | 8 | Received byte from the engine |
| ctrl_o | output | 8 | Control register contents |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A sequencer stuck in the wrong state shows up one access later: a flag that should have cleared is still visible in the next status read, or a flag that should have stayed set is missing. A wrong byte-direction bit shows up the same way, as a byte-done flag that survives the wrong data access. Errors in the flag store reach `irq_o` in the cycle after the bad edge, because the interrupt is combinational from the flags. Random access streams compare every read and every cycle's `irq_o` and `ctrl_o` against a reference model. Directed cases cover cancellation, set-beats-clear and freeze.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int unsigned NFLAG   = 8;
    localparam int unsigned ADDR_W  = 2;

    // flag indices; A-side flags occupy the low nibble of status A
    localparam int unsigned F_START = 0;
    localparam int unsigned F_HDR10 = 1;
    localparam int unsigned F_MATCH = 2;
    localparam int unsigned F_BYTE  = 3;
    localparam int unsigned F_STOP  = 4;
    localparam int unsigned F_ACKF  = 5;
    localparam int unsigned F_ARBL  = 6;
    localparam int unsigned F_BERR  = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_STATA = 2'd1,
        REG_STATB = 2'd2,
        REG_DATA  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic data_wr;   // armed, then data write
        logic data_rd;   // armed, then data read
        logic ctrl_wr;   // armed, then control write
        logic statb_rd;  // status B read, any state
    } seq_req_t;

endpackage

// File: rtl/i2c_evt_seq.sv
module i2c_evt_seq
    import i2c_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze_i,
    input  logic       acc_i,
    input  logic       wr_i,
    input  reg_sel_e   sel_i,
    output seq_req_t   req_o
);

    seq_state_e state_q, state_d;
    logic       live_acc;

    assign live_acc = acc_i && !freeze_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (live_acc) begin
            unique case (state_q)
                SEQ_IDLE:  state_d = (!wr_i && sel_i == REG_STATA) ? SEQ_ARMED : SEQ_IDLE;
                SEQ_ARMED: state_d = (!wr_i && sel_i == REG_STATA) ? SEQ_ARMED : SEQ_IDLE;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        req_o          = '0;
        req_o.statb_rd = live_acc && !wr_i && sel_i == REG_STATB;
        unique case (state_q)
            SEQ_IDLE: begin
            end
            SEQ_ARMED: begin
                req_o.data_wr = live_acc &&  wr_i && sel_i == REG_DATA;
                req_o.data_rd = live_acc && !wr_i && sel_i == REG_DATA;
                req_o.ctrl_wr = live_acc &&  wr_i && sel_i == REG_CTRL;
            end
            default: begin
            end
        endcase
    end

    // R7
    armed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == SEQ_ARMED) |-> $past(acc_i && !wr_i && sel_i == REG_STATA));

    // R10
    seq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(state_q));

endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic [NFLAG-1:0] set_i,
    input  logic             byte_rx_i,
    input  logic             byte_tx_i,
    input  seq_req_t         req_i,
    output logic [NFLAG-1:0] flag_o,
    output logic             evf_o
);

    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] clr;
    logic             last_rx_q;

    always_comb begin
        clr          = '0;
        clr[F_START] = req_i.data_wr;
        clr[F_HDR10] = req_i.data_wr;
        clr[F_MATCH] = req_i.ctrl_wr;
        clr[F_BYTE]  = (req_i.data_wr && !last_rx_q) || (req_i.data_rd && last_rx_q);
        clr[F_STOP]  = req_i.statb_rd;
        clr[F_ACKF]  = req_i.statb_rd;
        clr[F_ARBL]  = req_i.statb_rd;
        clr[F_BERR]  = req_i.statb_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_rx_q <= 1'b0;
        end else if (!freeze_i) begin
            if (byte_rx_i)      last_rx_q <= 1'b1;
            else if (byte_tx_i) last_rx_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q[g] <= 1'b0;
            else if (freeze_i)  flag_q[g] <= flag_q[g];
            else if (set_i[g])  flag_q[g] <= 1'b1;
            else if (clr[g])    flag_q[g] <= 1'b0;
        end

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!freeze_i && set_i[g]) |=> flag_q[g]);

        // R3
        clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[g]) |-> $past(clr[g]));
    end

    assign flag_o = flag_q;
    assign evf_o  = |flag_q;

    // R10
    flag_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(flag_q));

endmodule

// File: rtl/i2c_evt_irq_ctrl.sv
module i2c_evt_irq_ctrl
    import i2c_evt_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze_i,
    input  logic              imask_i,
    input  logic              ev_start_i,
    input  logic              ev_hdr10_i,
    input  logic              ev_match_i,
    input  logic              ev_byte_rx_i,
    input  logic              ev_byte_tx_i,
    input  logic              ev_stop_i,
    input  logic              ev_ack_fail_i,
    input  logic              ev_arb_lost_i,
    input  logic              ev_bus_err_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              irq_o
);

    localparam int unsigned SUM_BIT = DATA_W - 1;
    localparam int unsigned HALF    = NFLAG / 2;

    reg_sel_e          sel;
    seq_req_t          req;
    logic [NFLAG-1:0]  set_vec;
    logic [NFLAG-1:0]  flags;
    logic              evf;
    logic [DATA_W-1:0] ctrl_q;

    assign sel = reg_sel_e'(bus_addr_i);

    always_comb begin
        set_vec          = '0;
        set_vec[F_START] = ev_start_i;
        set_vec[F_HDR10] = ev_hdr10_i;
        set_vec[F_MATCH] = ev_match_i;
        set_vec[F_BYTE]  = ev_byte_rx_i || ev_byte_tx_i;
        set_vec[F_STOP]  = ev_stop_i;
        set_vec[F_ACKF]  = ev_ack_fail_i;
        set_vec[F_ARBL]  = ev_arb_lost_i;
        set_vec[F_BERR]  = ev_bus_err_i;
    end

    i2c_evt_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (freeze_i),
        .acc_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .sel_i    (sel),
        .req_o    (req)
    );

    i2c_evt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_i  (freeze_i),
        .set_i     (set_vec),
        .byte_rx_i (ev_byte_rx_i),
        .byte_tx_i (ev_byte_tx_i),
        .req_i     (req),
        .flag_o    (flags),
        .evf_o     (evf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (!freeze_i && bus_sel_i && bus_wr_i && sel == REG_CTRL) begin
            ctrl_q <= bus_wdata_i;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            REG_CTRL:  bus_rdata_o = ctrl_q;
            REG_STATA: begin
                bus_rdata_o[HALF-1:0] = flags[HALF-1:0];
                bus_rdata_o[SUM_BIT]  = evf;
            end
            REG_STATB: bus_rdata_o[HALF-1:0] = flags[NFLAG-1:HALF];
            REG_DATA:  bus_rdata_o = rx_data_i;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = evf && ctrl_q[IE_BIT] && !imask_i;

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != '0));

    // R11
    ctrl_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(ctrl_q));

endmodule

// File: tb/i2c_evt_irq_ctrl_tb_top.sv
module i2c_evt_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       freeze = 1'b0, imask = 1'b0;
    logic [8:0] ev = '0;  // start,hdr10,match,rx,tx,stop,ackf,arbl,berr
    logic       sel = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rxd = 8'h3C;
    logic [7:0] rdata, ctrl;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_flag = '0;
    logic       m_rx = 1'b0, m_armed = 1'b0;
    logic [7:0] m_ctrl = '0;

    always #2 clk = ~clk;

    i2c_evt_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze), .imask_i(imask),
        .ev_start_i(ev[0]), .ev_hdr10_i(ev[1]), .ev_match_i(ev[2]),
        .ev_byte_rx_i(ev[3]), .ev_byte_tx_i(ev[4]), .ev_stop_i(ev[5]),
        .ev_ack_fail_i(ev[6]), .ev_arb_lost_i(ev[7]), .ev_bus_err_i(ev[8]),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .rx_data_i(rxd), .ctrl_o(ctrl), .irq_o(irq)
    );

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return {|m_flag, 3'b000, m_flag[3:0]};
            2'd2:    return {4'b0000, m_flag[7:4]};
            default: return rxd;
        endcase
    endfunction

    function automatic logic m_irq();
        return (|m_flag) && m_ctrl[0] && !imask;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_step();
        logic [7:0] clr, setv;
        if (freeze) return;
        clr = '0;
        if (sel && !wr && addr == 2'd2) clr[7:4] = 4'hF;
        if (m_armed && sel) begin
            if (wr && addr == 2'd3) begin
                clr[0] = 1'b1; clr[1] = 1'b1;
                if (!m_rx) clr[3] = 1'b1;
            end
            if (!wr && addr == 2'd3 && m_rx) clr[3] = 1'b1;
            if (wr && addr == 2'd0) clr[2] = 1'b1;
        end
        setv = {ev[8], ev[7], ev[6], ev[5], ev[3] | ev[4], ev[2], ev[1], ev[0]};
        m_flag = (m_flag & ~clr) | setv;
        if (ev[3]) m_rx = 1'b1;
        else if (ev[4]) m_rx = 1'b0;
        if (sel) m_armed = !wr && addr == 2'd1;
        if (sel && wr && addr == 2'd0) m_ctrl = wdata;
    endtask

    // one clock: inputs already driven at a falling edge
    task automatic tick(input string tag);
        #1;
        if (sel && !wr) check(rdata, m_read(addr), tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        check({7'b0, irq}, {7'b0, m_irq()}, "R9 irq");
        check(ctrl, m_ctrl, "R11 ctrl_o");
        sel = 1'b0; wr = 1'b0; ev = '0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        sel = 1'b1; wr = 1'b0; addr = a;
        tick(tag);
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [7:0] exp, input string tag);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 check(rdata, exp, tag);
        tick(tag);
    endtask

    task automatic wrr(input logic [1:0] a, input logic [7:0] d, input string tag);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        tick(tag);
    endtask

    task automatic pulse(input logic [8:0] e, input string tag);
        ev = e;
        tick(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        r = $urandom(32'h1C2E);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({7'b0, irq}, 8'h00, "R1 irq");
        check(ctrl, 8'h00, "R1 ctrl");
        rd_exp(2'd1, 8'h00, "R1 statA");
        rd_exp(2'd2, 8'h00, "R1 statB");
        wrr(2'd3, 8'h11, "R1 idle data write");
        // R2 set all
        pulse(9'h1FF, "R2 all events");
        rd_exp(2'd1, 8'h8F, "R2 statA");
        rd_exp(2'd2, 8'h0F, "R2 statB");
        // R3 cleared, pending A read cancelled
        rd_exp(2'd2, 8'h00, "R3 statB cleared");
        wrr(2'd3, 8'h22, "R3 cancel");
        rd_exp(2'd1, 8'h8F, "R7 cancelled write kept flags");
        // R4 data write after A read: last byte rx, so byte-done stays
        wrr(2'd3, 8'h33, "R4 data write");
        rd_exp(2'd1, 8'h8C, "R4 start/hdr cleared");
        rd(2'd3, "R5 data read value");
        rd_exp(2'd1, 8'h84, "R5 byte-done cleared");
        wrr(2'd0, 8'h01, "R6 control write");
        rd_exp(2'd1, 8'h00, "R6 match cleared");
        // R7 intervening access cancels; idle cycles do not
        pulse(9'h001, "R7 start");
        rd(2'd1, "R7 arm");
        rd(2'd0, "R7 other access");
        wrr(2'd3, 8'h00, "R7 late write");
        rd_exp(2'd1, 8'h81, "R7 start kept");
        rd(2'd1, "R7 re-arm");
        tick("R7 gap");
        wrr(2'd3, 8'h00, "R7 complete");
        rd_exp(2'd1, 8'h00, "R7 cleared");
        // R4 transmit byte
        pulse(9'h010, "R4 tx byte");
        rd_exp(2'd1, 8'h88, "R4 byte-done set");
        rd(2'd3, "R4 data read does not clear tx");
        rd_exp(2'd1, 8'h88, "R4 still set");
        wrr(2'd3, 8'h00, "R4 write clears tx byte");
        rd_exp(2'd1, 8'h00, "R4 tx cleared");
        // R8 set beats clear
        pulse(9'h001, "R8 start");
        rd(2'd1, "R8 arm");
        sel = 1'b1; wr = 1'b1; addr = 2'd3; ev = 9'h001;
        tick("R8 collide");
        rd_exp(2'd1, 8'h81, "R8 set wins");
        wrr(2'd3, 8'h00, "R8 clear");
        // R9 interrupt gating
        pulse(9'h020, "R9 stop");
        check({7'b0, irq}, 8'h01, "R9 irq on");
        imask = 1'b1; #1 check({7'b0, irq}, 8'h00, "R9 masked");
        imask = 1'b0;
        wrr(2'd0, 8'h00, "R9 disable");
        check({7'b0, irq}, 8'h00, "R9 disabled");
        wrr(2'd0, 8'h01, "R9 enable");
        rd(2'd2, "R9 clear stop");
        check({7'b0, irq}, 8'h00, "R9 cleared");
        // R10 freeze
        pulse(9'h020, "R10 stop");
        freeze = 1'b1;
        pulse(9'h001, "R10 frozen event");
        wrr(2'd0, 8'hFF, "R10 frozen write");
        rd(2'd2, "R10 frozen read");
        freeze = 1'b0;
        rd_exp(2'd2, 8'h01, "R10 stop held");
        rd_exp(2'd1, 8'h00, "R10 start ignored");
        check(ctrl, 8'h01, "R10 ctrl held");
        // R11
        wrr(2'd0, 8'hA5, "R11 write");
        rd_exp(2'd0, 8'hA5, "R11 readback");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            r = $urandom();
            ev     = (r[3:0] == 4'd0) ? 9'($urandom()) : '0;
            sel    = r[4] | r[5];
            wr     = r[6];
            addr   = r[8:7];
            wdata  = 8'($urandom());
            freeze = (r[12:9] == 4'd0);
            imask  = (r[15:13] == 3'd0);
            rxd    = r[23:16];
            tick("R2 R7 random");
        end
        freeze = 1'b0; imask = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule